// File: doc/BRIEF.md
# Peripheral Interrupt Request Mapper

This block gathers 32 peripheral interrupt request lines and folds them onto 12 user interrupt levels. Each source holds a 4-bit assignment, written through a small register port, that names the level it drives. Several sources may share one level. A source whose field holds a value outside the level range drives nothing. The level a source is given sets its service priority, because lower-numbered levels win over higher-numbered ones.

Beside the user levels, five fixed sources reach the core directly: reset, emulator, stack, emulator kernel and power down. They are level-sensitive and cannot be masked. A 17-entry priority encoder reports the single most urgent pending and unmasked request as a 5-bit index with a valid flag. The core acknowledges a user level by presenting that level's index. This clears the level's pending latch.

Each user level's pending bit is a sticky latch. It is set by a rising edge of the level's merged request. It is cleared by an acknowledge of that level. A per-level mask hides a pending level from the encoder without discarding it.

Top module: `irq_mapper_top`

## Requirements
- R1: Writing `map_we`=1 with `map_addr`=S and `map_data`=V (0..11) on a clock edge assigns source S to user level V from the next cycle on.
- R2: A source whose map field holds 12, 13, 14 or 15 never sets any pending bit, whatever its request does.
- R3: A level's merged request is the OR of the requests of all sources currently mapped to it, so several sources may share one level.
- R4: A level's pending bit (`lvl_pending` bit L) becomes 1 on the clock edge where its merged request is 1 and was 0 on the previous edge. It stays 1 until acknowledged, even after the request falls. A request that merely stays high does not set it again.
- R5: `ack_valid`=1 with `ack_idx`=5+L clears pending bit L on that edge. If the level's request rises on the same edge, the bit stays set. Acknowledges with index 0..4 or above 16 change no pending bit.
- R6: Writing `mask_we`=1 loads `mask_data` into the level mask. Mask bit L=1 keeps level L out of the vector, but its pending bit is still recorded and shown on `lvl_pending`.
- R7: The vector index encodes 0=reset, 1=emulator, 2=stack, 3=emulator kernel, 4=power down, 5+L=user level L. The lowest index among active sources is reported.
- R8: The fixed sources (`fix_req` bit i drives index i) act on the vector in the same cycle they are asserted, with no latching. No mask affects them, so reset always wins.
- R9: When no fixed source is asserted and no pending level is unmasked, `vec_valid`=0 and `vec_idx`=0.
- R10: After synchronous reset, every map field reads as unassigned (15), every mask bit is 1, and no level is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_we | input | 1 | Map field write strobe |
| map_addr | input | 5 | Source whose field is written |
| map_data | input | 4 | Level to assign (12..15 unassigns) |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | 12 | New level mask, 1 = masked |
| irq_req | input | 32 | Peripheral request lines |
| fix_req | input | 5 | Fixed sources: reset, emulator, stack, kernel, power down |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | 5 | Vector index being acknowledged |
| lvl_pending | output | 12 | Pending latch of each user level |
| vec_valid | output | 1 | A source is being requested |
| vec_idx | output | 5 | Index of the most urgent active source |

## Verification
On every cycle, the assertions check four properties. A rising merged request always leaves its pending bit set. An acknowledge with no coincident rise always leaves the bit clear. An asserted reset source always owns the vector. A reported user level is never a masked one. They also check that the mask leaves reset fully closed and that no level request appears without some peripheral request behind it. Only the bench's scenarios can show the rest: that a written map field steers a source to the intended level, and that unassigned fields stay silent. They also show how priority resolves when several levels and fixed sources compete, and that stray acknowledges are ignored. The bench compares against a behavioural model on every clock, including a long randomized stretch of remapping and acknowledges.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;
    localparam int NUM_SRC = 32;
    localparam int NUM_LVL = 12;
    localparam int MAP_W   = 4;
    localparam int NUM_FIX = 5;
    localparam int NUM_VEC = NUM_FIX + NUM_LVL;
    localparam int VEC_W   = $clog2(NUM_VEC);
    localparam int SRC_W   = $clog2(NUM_SRC);

    typedef enum logic [VEC_W-1:0] {
        VEC_RESET  = 5'd0,
        VEC_EMU    = 5'd1,
        VEC_STACK  = 5'd2,
        VEC_KERNEL = 5'd3,
        VEC_PWRDN  = 5'd4,
        VEC_USER0  = 5'd5
    } vec_id_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] idx;
    } vec_t;

    // Lowest set bit wins; bit position equals vector index.
    function automatic vec_t pick_first(input logic [NUM_VEC-1:0] act);
        vec_t r;
        r = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (act[i]) begin
                r.valid = 1'b1;
                r.idx   = VEC_W'(i);
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_map_table.sv
module irq_map_table
    import irq_map_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int NLVL = NUM_LVL,
    parameter int MW   = MAP_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [$clog2(NSRC)-1:0] wr_addr,
    input  logic [MW-1:0]           wr_data,
    input  logic [NSRC-1:0]         req,
    output logic [NLVL-1:0]         lvl_req
);
    localparam logic [MW-1:0] UNASSIGNED = '1;

    logic [MW-1:0] field_q [NSRC];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSRC; s++) field_q[s] <= UNASSIGNED;
        end else if (wr_en) begin
            field_q[wr_addr] <= wr_data;
        end
    end

    // Per-level OR of all sources whose field names that level.
    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        logic [NSRC-1:0] hit;
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            assign hit[s] = req[s] && (field_q[s] == MW'(l));
        end
        assign lvl_req[l] = |hit;
    end

    // R3: a level request only exists with a peripheral request behind it
    p_route_has_source_r3: assert property (@(posedge clk) disable iff (rst)
        (|lvl_req) |-> (|req));
endmodule

// File: rtl/irq_level_pend.sv
module irq_level_pend
    import irq_map_pkg::*;
#(
    parameter int NLVL = NUM_LVL,
    parameter int VW   = VEC_W,
    parameter int BASE = NUM_FIX
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NLVL-1:0] lvl_req,
    input  logic            ack_valid,
    input  logic [VW-1:0]   ack_idx,
    input  logic            mask_we,
    input  logic [NLVL-1:0] mask_data,
    output logic [NLVL-1:0] pend,
    output logic [NLVL-1:0] mask
);
    logic [NLVL-1:0] lvl_q;
    logic [NLVL-1:0] rise;
    logic [NLVL-1:0] ack_hit;

    for (genvar l = 0; l < NLVL; l++) begin : g_ack
        assign ack_hit[l] = ack_valid && (ack_idx == VW'(BASE + l));
    end

    assign rise = lvl_req & ~lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            pend  <= '0;
            mask  <= '1;
        end else begin
            lvl_q <= lvl_req;
            pend  <= rise | (pend & ~ack_hit);
            if (mask_we) mask <= mask_data;
        end
    end

    for (genvar l = 0; l < NLVL; l++) begin : g_chk
        // R4: a rising merged request leaves the level pending
        p_rise_sets_r4: assert property (@(posedge clk) disable iff (rst)
            $rose(lvl_req[l]) |=> pend[l]);
        // R5: acknowledge without a coincident rise clears the level
        p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
            (ack_valid && ack_idx == VW'(BASE + l) && !$rose(lvl_req[l])) |=> !pend[l]);
    end

    // R10: leaving reset, every level is masked and none pending
    p_reset_state_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((&mask) && (pend == '0)));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_map_pkg::*;
(
    input  logic [NUM_FIX-1:0] fix_req,
    input  logic [NUM_LVL-1:0] pend,
    input  logic [NUM_LVL-1:0] mask,
    output vec_t               vec
);
    logic [NUM_VEC-1:0] active;

    assign active = {pend & ~mask, fix_req};
    assign vec    = pick_first(active);

    // R8: the reset source is never hidden
    always_comb begin
        p_reset_wins_r8: assert (!fix_req[VEC_RESET] || (vec.valid && vec.idx == VEC_RESET));
    end
endmodule

// File: rtl/irq_mapper_top.sv
module irq_mapper_top
    import irq_map_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               map_we,
    input  logic [SRC_W-1:0]   map_addr,
    input  logic [MAP_W-1:0]   map_data,
    input  logic               mask_we,
    input  logic [NUM_LVL-1:0] mask_data,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_FIX-1:0] fix_req,
    input  logic               ack_valid,
    input  logic [VEC_W-1:0]   ack_idx,
    output logic [NUM_LVL-1:0] lvl_pending,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_idx
);
    logic [NUM_LVL-1:0] lvl_req;
    logic [NUM_LVL-1:0] mask;
    vec_t               vec;

    irq_map_table #(.NSRC(NUM_SRC), .NLVL(NUM_LVL), .MW(MAP_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (map_we),
        .wr_addr (map_addr),
        .wr_data (map_data),
        .req     (irq_req),
        .lvl_req (lvl_req)
    );

    irq_level_pend #(.NLVL(NUM_LVL), .VW(VEC_W), .BASE(NUM_FIX)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .lvl_req   (lvl_req),
        .ack_valid (ack_valid),
        .ack_idx   (ack_idx),
        .mask_we   (mask_we),
        .mask_data (mask_data),
        .pend      (lvl_pending),
        .mask      (mask)
    );

    irq_prio_enc u_enc (
        .fix_req (fix_req),
        .pend    (lvl_pending),
        .mask    (mask),
        .vec     (vec)
    );

    assign vec_valid = vec.valid;
    assign vec_idx   = vec.idx;

    logic [NUM_VEC-1:0] blocked;
    assign blocked = {mask, {NUM_FIX{1'b0}}};

    // R6: a reported vector never names a masked level
    p_masked_hidden_r6: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> !blocked[vec_idx]);
    // R9: an idle vector reads as index zero
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> (vec_idx == '0));
endmodule

// File: tb/irq_mapper_top_bench.sv
`timescale 1ns/1ps
module irq_mapper_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        map_we = 1'b0;
    logic [4:0]  map_addr = '0;
    logic [3:0]  map_data = '0;
    logic        mask_we = 1'b0;
    logic [11:0] mask_data = '0;
    logic [31:0] irq_req = '0;
    logic [4:0]  fix_req = '0;
    logic        ack_valid = 1'b0;
    logic [4:0]  ack_idx = '0;
    logic [11:0] lvl_pending;
    logic        vec_valid;
    logic [4:0]  vec_idx;

    always #2.5 clk = ~clk;

    irq_mapper_top u_irq_mapper_top (
        .clk(clk), .rst(rst), .map_we(map_we), .map_addr(map_addr), .map_data(map_data),
        .mask_we(mask_we), .mask_data(mask_data), .irq_req(irq_req), .fix_req(fix_req),
        .ack_valid(ack_valid), .ack_idx(ack_idx), .lvl_pending(lvl_pending),
        .vec_valid(vec_valid), .vec_idx(vec_idx)
    );

    // Behavioural reference state
    int    ref_map [32];
    bit    ref_pend [12];
    bit    ref_prev [12];
    bit    ref_mask [12];
    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R10";
    bit    done = 1'b0;

    task automatic model_edge();
        bit lr [12];
        if (rst) begin
            foreach (ref_map[s]) ref_map[s] = 15;
            for (int l = 0; l < 12; l++) begin
                ref_pend[l] = 0; ref_prev[l] = 0; ref_mask[l] = 1;
            end
            return;
        end
        for (int l = 0; l < 12; l++) lr[l] = 0;
        for (int s = 0; s < 32; s++)
            if (irq_req[s] && ref_map[s] < 12) lr[ref_map[s]] = 1;
        for (int l = 0; l < 12; l++) begin
            bit hit;
            hit = ack_valid && (int'(ack_idx) == 5 + l);
            ref_pend[l] = (lr[l] && !ref_prev[l]) || (ref_pend[l] && !hit);
            ref_prev[l] = lr[l];
        end
        if (map_we) ref_map[map_addr] = int'(map_data);
        if (mask_we) for (int l = 0; l < 12; l++) ref_mask[l] = mask_data[l];
    endtask

    task automatic compare();
        logic [11:0] ep;
        bit          ev;
        int          ei;
        ev = 0; ei = 0;
        for (int l = 0; l < 12; l++) ep[l] = ref_pend[l];
        for (int i = 16; i >= 0; i--) begin
            bit a;
            a = (i < 5) ? fix_req[i] : (ref_pend[i-5] && !ref_mask[i-5]);
            if (a) begin ev = 1; ei = i; end
        end
        n_cmp++;
        if (lvl_pending !== ep || vec_valid !== ev || int'(vec_idx) !== ei) begin
            n_bad++;
            $display("FAIL %s: pend=%h valid=%b idx=%0d expected pend=%h valid=%b idx=%0d",
                     tag, lvl_pending, vec_valid, vec_idx, ep, ev, ei);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        compare();
        @(negedge clk);
    endtask

    task automatic wr_map(input int src, input int lvl);
        map_we = 1; map_addr = 5'(src); map_data = 4'(lvl);
        tick();
        map_we = 0;
    endtask

    task automatic wr_mask(input logic [11:0] m);
        mask_we = 1; mask_data = m;
        tick();
        mask_we = 0;
    endtask

    task automatic ack(input int idx);
        ack_valid = 1; ack_idx = 5'(idx);
        tick();
        ack_valid = 0;
    endtask

    initial begin
        @(negedge clk);
        tag = "R10"; tick(); tick();
        rst = 0;
        tag = "R10"; tick();
        // R10: masked by default, so a mapped request pends but stays hidden
        wr_map(0, 0);
        irq_req[0] = 1; tick(); tick();
        irq_req[0] = 0; ack(5); tick();

        tag = "R6"; wr_mask(12'h000);
        tag = "R1"; wr_map(3, 2);
        irq_req[3] = 1; tick(); tick();
        tag = "R4"; irq_req[3] = 0; tick(); tick();
        tag = "R5"; ack(7); tick();
        tag = "R4"; irq_req[3] = 1; tick(); ack(7); tick(); tick();
        irq_req[3] = 0; tick();

        tag = "R3"; wr_map(9, 4); wr_map(10, 4);
        irq_req[9] = 1; tick(); irq_req[10] = 1; tick();
        irq_req[9] = 0; tick(); irq_req[10] = 0; tick(); ack(9); tick();
        irq_req[10] = 1; tick(); irq_req[10] = 0; ack(9); tick();

        tag = "R2";
        for (int v = 12; v < 16; v++) begin
            wr_map(7, v);
            irq_req[7] = 1; tick(); tick();
            irq_req[7] = 0; tick();
        end

        tag = "R5"; wr_map(11, 6);
        irq_req[11] = 1; tick(); irq_req[11] = 0; tick();
        ack(2); ack(4); ack(31); ack(10); tick();
        irq_req[11] = 1; ack(11); tick();
        irq_req[11] = 0; ack(11); tick();

        tag = "R7"; wr_map(20, 1); wr_map(21, 8);
        irq_req[21] = 1; tick(); irq_req[20] = 1; tick();
        ack(6); tick(); ack(13); tick();
        irq_req[20] = 0; irq_req[21] = 0; tick();

        tag = "R6"; irq_req[20] = 1; tick(); irq_req[21] = 1; tick();
        wr_mask(12'h002); tick(); wr_mask(12'h102); tick();
        wr_mask(12'h000); tick(); ack(6); ack(13);
        irq_req[20] = 0; irq_req[21] = 0; tick();

        tag = "R8"; wr_map(5, 0); irq_req[5] = 1; tick();
        for (int f = 4; f >= 0; f--) begin fix_req[f] = 1; tick(); end
        wr_mask(12'hFFF); tick();
        for (int f = 0; f < 5; f++) begin fix_req[f] = 0; tick(); end
        wr_mask(12'h000); ack(5); irq_req[5] = 0; tick();

        tag = "R9"; tick();

        tag = "R7";
        for (int c = 0; c < 600; c++) begin
            irq_req   = $urandom & $urandom & $urandom;
            fix_req   = (($urandom % 8) == 0) ? 5'($urandom) : 5'd0;
            map_we    = ($urandom % 4) == 0;
            map_addr  = 5'($urandom);
            map_data  = 4'($urandom);
            mask_we   = ($urandom % 16) == 0;
            mask_data = 12'($urandom);
            ack_valid = ($urandom % 2) == 0;
            ack_idx   = vec_valid ? vec_idx : 5'($urandom % 20);
            tick();
        end
        map_we = 0; mask_we = 0; ack_valid = 0; irq_req = '0; fix_req = '0;
        tick();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule